// File: doc/BRIEF.md
# Operand Bypass Select and Load-Use Interlock

This block resolves read-after-write hazards for a five-stage in-order pipeline (fetch, decode, execute, data access, write-back). Decode presents, each cycle, the register tags of the instruction it holds: up to three source register numbers, each with a "used" bit, plus its destination number, write enable and a load flag. The block carries those tags down its own small shadow pipeline, so it always knows which instruction sits in execute, in the execute/data register and in the data/write-back register.

For every source operand of the instruction in execute, it drives a two-bit select. The select steers the operand mux in execute to one of three values: the register-file read value, the ALU result held in the execute/data register, or the result held in the data/write-back register. A load whose destination is read by the instruction right behind it cannot be covered by bypassing. For that case the block raises a stall that freezes the program counter and the fetch/decode register, and it asks execute to take a no-op. One cycle later the loaded value sits in the data/write-back register and is bypassed from there.

Top module: `hzfwd_unit`

## Requirements
- R1: While reset is asserted and directly after it, every operand select reads 00 (register file) and stall_fd and bubble_ex are low.
- R2: A source operand of the execute instruction selects 01 (execute/data result) when the instruction one ahead is valid, has write enable, and its destination equals that source.
- R3: If the R2 condition does not hold but the instruction two ahead is valid, writes, and has that destination, the select is 10 (data/write-back result).
- R4: When both older instructions write the same source register, the younger one (select 01) wins.
- R5: A producer without write enable, a bubble, or an invalid slot never causes a select other than 00.
- R6: A destination equal to the program-counter register number (15 by default) is never bypassed and never triggers a stall.
- R7: stall_fd and bubble_ex rise together in the cycle when decode holds a valid instruction with a used source equal to the destination of a valid, writing load in execute.
- R8: A load-use stall lasts exactly one cycle. In the cycle after it, the held consumer is in execute and takes the loaded value with select 10, never 01.
- R9: A source whose used bit is low always selects 00 and never causes a stall.
- R10: Each of the three operands is compared on its own. Operand 2, the highest one, bypasses and interlocks exactly as operand 0 does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| id_vld | input | 1 | Decode holds a real instruction |
| id_src | input | NSRC*AW | Source register numbers; operand i at bits i*AW +: AW |
| id_used | input | NSRC | Operand i is read by the instruction |
| id_dst | input | AW | Destination register number |
| id_wen | input | 1 | Instruction writes its destination |
| id_load | input | 1 | Instruction is a memory load |
| fwd_sel | output | 2*NSRC | Operand i select at bits 2*i +: 2: 00 register file, 01 execute/data, 10 data/write-back |
| stall_fd | output | 1 | Hold program counter and fetch/decode register |
| bubble_ex | output | 1 | Load a no-op into the decode/execute register |

## Verification
The bench builds the block with its defaults: 4-bit register numbers, three operands, register 15 as the program counter, and program-counter bypass blocked. Random register numbers are drawn from a pool of five (r0 to r3 and r15). This makes back-to-back matches, double matches on one register, loads followed by their consumer, and writes to the program counter frequent. The bench's stage model can then reach the priority, suppression, and single-stall cases on every operand. Directed sequences pin down the load-use pair and the both-older-writers case on operand 2.

// File: rtl/hzfwd_pkg.sv
package hzfwd_pkg;

   // operand mux steering code
   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_EXMEM   = 2'b01,
      SEL_MEMWB   = 2'b10
   } fwd_src_e;

endpackage

// File: rtl/hzfwd_stage_regs.sv
module hzfwd_stage_regs #(
   parameter int AW   = 4,
   parameter int NSRC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins_bubble,
   input  logic              id_vld,
   input  logic [NSRC*AW-1:0] id_src,
   input  logic [NSRC-1:0]   id_used,
   input  logic [AW-1:0]     id_dst,
   input  logic              id_wen,
   input  logic              id_load,
   output logic              ex_vld,
   output logic              ex_wen,
   output logic              ex_ld,
   output logic [AW-1:0]     ex_dst,
   output logic [NSRC*AW-1:0] ex_src,
   output logic [NSRC-1:0]   ex_used,
   output logic              mem_vld,
   output logic              mem_wen,
   output logic [AW-1:0]     mem_dst,
   output logic              wb_vld,
   output logic              wb_wen,
   output logic [AW-1:0]     wb_dst
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ex_vld  <= 1'b0;
         ex_wen  <= 1'b0;
         ex_ld   <= 1'b0;
         ex_dst  <= '0;
         ex_src  <= '0;
         ex_used <= '0;
         mem_vld <= 1'b0;
         mem_wen <= 1'b0;
         mem_dst <= '0;
         wb_vld  <= 1'b0;
         wb_wen  <= 1'b0;
         wb_dst  <= '0;
      end else begin
         // older slots simply shift
         wb_vld  <= mem_vld;
         wb_wen  <= mem_wen;
         wb_dst  <= mem_dst;
         mem_vld <= ex_vld;
         mem_wen <= ex_wen;
         mem_dst <= ex_dst;
         ex_dst  <= id_dst;
         ex_src  <= id_src;
         if (ins_bubble) begin
            ex_vld  <= 1'b0;
            ex_wen  <= 1'b0;
            ex_ld   <= 1'b0;
            ex_used <= '0;
         end else begin
            ex_vld  <= id_vld;
            ex_wen  <= id_wen;
            ex_ld   <= id_load;
            ex_used <= id_used;
         end
      end
   end

endmodule

// File: rtl/hzfwd_writer_qual.sv
module hzfwd_writer_qual #(
   parameter int AW       = 4,
   parameter int PC_REG   = 15,
   parameter bit BLOCK_PC = 1'b1
) (
   input  logic          vld,
   input  logic          wen,
   input  logic [AW-1:0] dst,
   output logic          writes
);

   localparam logic [AW-1:0] PC_IDX = AW'(PC_REG);

   generate
      if (BLOCK_PC) begin : g_block_pc
         assign writes = vld & wen & (dst != PC_IDX);
      end else begin : g_any_dst
         assign writes = vld & wen;
      end
   endgenerate

endmodule

// File: rtl/hzfwd_opsel.sv
module hzfwd_opsel
   import hzfwd_pkg::*;
#(
   parameter int AW = 4
) (
   input  logic          used,
   input  logic [AW-1:0] src,
   input  logic          exm_writes,
   input  logic [AW-1:0] exm_dst,
   input  logic          mwb_writes,
   input  logic [AW-1:0] mwb_dst,
   output fwd_src_e      sel
);

   logic hit_exm;
   logic hit_mwb;

   assign hit_exm = used & exm_writes & (exm_dst == src);
   assign hit_mwb = used & mwb_writes & (mwb_dst == src);

   // younger producer checked first
   always_comb begin
      if (hit_exm)      sel = SEL_EXMEM;
      else if (hit_mwb) sel = SEL_MEMWB;
      else              sel = SEL_REGFILE;
   end

endmodule

// File: rtl/hzfwd_loaduse.sv
module hzfwd_loaduse #(
   parameter int AW   = 4,
   parameter int NSRC = 3
) (
   input  logic               id_vld,
   input  logic [NSRC*AW-1:0] id_src,
   input  logic [NSRC-1:0]    id_used,
   input  logic               ex_writes,
   input  logic               ex_ld,
   input  logic [AW-1:0]      ex_dst,
   output logic               hazard
);

   logic [NSRC-1:0] op_hit;

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_cmp
         assign op_hit[gi] = id_used[gi] & (id_src[gi*AW +: AW] == ex_dst);
      end
   endgenerate

   assign hazard = id_vld & ex_writes & ex_ld & (|op_hit);

endmodule

// File: rtl/hzfwd_unit.sv
module hzfwd_unit
   import hzfwd_pkg::*;
#(
   parameter int AW       = 4,
   parameter int NSRC     = 3,
   parameter int PC_REG   = 15,
   parameter bit BLOCK_PC = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               id_vld,
   input  logic [NSRC*AW-1:0] id_src,
   input  logic [NSRC-1:0]    id_used,
   input  logic [AW-1:0]      id_dst,
   input  logic               id_wen,
   input  logic               id_load,
   output logic [2*NSRC-1:0]  fwd_sel,
   output logic               stall_fd,
   output logic               bubble_ex
);

   localparam int SELW = 2;

   generate
      if (AW < 2 || AW > 8) begin : g_bad_aw
         $error("hzfwd_unit: AW must lie in 2..8");
      end
      if (NSRC < 1 || NSRC > 4) begin : g_bad_nsrc
         $error("hzfwd_unit: NSRC must lie in 1..4");
      end
      if (PC_REG < 0 || PC_REG >= (1 << AW)) begin : g_bad_pc
         $error("hzfwd_unit: PC_REG outside register space");
      end
   endgenerate

   logic               ex_vld, ex_wen, ex_ld;
   logic [AW-1:0]      ex_dst;
   logic [NSRC*AW-1:0] ex_src;
   logic [NSRC-1:0]    ex_used;
   logic               mem_vld, mem_wen;
   logic [AW-1:0]      mem_dst;
   logic               wb_vld, wb_wen;
   logic [AW-1:0]      wb_dst;
   logic               ex_writes, mem_writes, wb_writes;
   logic               lu_hazard;

   hzfwd_stage_regs #(.AW(AW), .NSRC(NSRC)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .ins_bubble(lu_hazard),
      .id_vld    (id_vld),
      .id_src    (id_src),
      .id_used   (id_used),
      .id_dst    (id_dst),
      .id_wen    (id_wen),
      .id_load   (id_load),
      .ex_vld    (ex_vld),
      .ex_wen    (ex_wen),
      .ex_ld     (ex_ld),
      .ex_dst    (ex_dst),
      .ex_src    (ex_src),
      .ex_used   (ex_used),
      .mem_vld   (mem_vld),
      .mem_wen   (mem_wen),
      .mem_dst   (mem_dst),
      .wb_vld    (wb_vld),
      .wb_wen    (wb_wen),
      .wb_dst    (wb_dst)
   );

   hzfwd_writer_qual #(.AW(AW), .PC_REG(PC_REG), .BLOCK_PC(BLOCK_PC)) u_q_ex (
      .vld(ex_vld), .wen(ex_wen), .dst(ex_dst), .writes(ex_writes)
   );
   hzfwd_writer_qual #(.AW(AW), .PC_REG(PC_REG), .BLOCK_PC(BLOCK_PC)) u_q_mem (
      .vld(mem_vld), .wen(mem_wen), .dst(mem_dst), .writes(mem_writes)
   );
   hzfwd_writer_qual #(.AW(AW), .PC_REG(PC_REG), .BLOCK_PC(BLOCK_PC)) u_q_wb (
      .vld(wb_vld), .wen(wb_wen), .dst(wb_dst), .writes(wb_writes)
   );

   hzfwd_loaduse #(.AW(AW), .NSRC(NSRC)) u_lu (
      .id_vld   (id_vld),
      .id_src   (id_src),
      .id_used  (id_used),
      .ex_writes(ex_writes),
      .ex_ld    (ex_ld),
      .ex_dst   (ex_dst),
      .hazard   (lu_hazard)
   );

   genvar gi;
   generate
      for (gi = 0; gi < NSRC; gi++) begin : g_op
         fwd_src_e op_sel;
         hzfwd_opsel #(.AW(AW)) u_sel (
            .used      (ex_used[gi] & ex_vld),
            .src       (ex_src[gi*AW +: AW]),
            .exm_writes(mem_writes),
            .exm_dst   (mem_dst),
            .mwb_writes(wb_writes),
            .mwb_dst   (wb_dst),
            .sel       (op_sel)
         );
         assign fwd_sel[gi*SELW +: SELW] = op_sel;
      end
   endgenerate

   assign stall_fd  = lu_hazard;
   assign bubble_ex = lu_hazard;

endmodule

// File: rtl/hzfwd_chk.sv
module hzfwd_chk #(
   parameter int NSRC = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic [2*NSRC-1:0] fwd_sel,
   input logic              stall_fd,
   input logic              bubble_ex,
   input logic              ex_vld,
   input logic              ex_ld
);

   logic any_exm;
   logic any_bad;
   logic all_rf;

   always_comb begin
      any_exm = 1'b0;
      any_bad = 1'b0;
      all_rf  = 1'b1;
      for (int i = 0; i < NSRC; i++) begin
         if (fwd_sel[2*i +: 2] == 2'b01) any_exm = 1'b1;
         if (fwd_sel[2*i +: 2] == 2'b11) any_bad = 1'b1;
         if (fwd_sel[2*i +: 2] != 2'b00) all_rf = 1'b0;
      end
   end

   // R7
   stall_bubble_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_fd == bubble_ex);

   // R8
   single_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stall_fd |=> !stall_fd);

   // R8
   no_exm_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      any_exm |-> !($past(ex_vld) && $past(ex_ld)));

   // R5
   bubble_reads_rf_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bubble_ex |=> all_rf);

   // R2
   legal_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !any_bad);

endmodule

bind hzfwd_unit hzfwd_chk #(.NSRC(NSRC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .fwd_sel  (fwd_sel),
   .stall_fd (stall_fd),
   .bubble_ex(bubble_ex),
   .ex_vld   (ex_vld),
   .ex_ld    (ex_ld)
);

// File: tb/hzfwd_unit_tb_top.sv
`timescale 1ns/1ps
module hzfwd_unit_tb_top;

   localparam int AW = 4;
   localparam int NS = 3;
   localparam int PC = 15;

   typedef struct {
      bit v; bit w; bit l; int d;
      int s[NS]; bit u[NS];
   } slot_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic id_vld = 1'b0;
   logic [NS*AW-1:0] id_src = '0;
   logic [NS-1:0] id_used = '0;
   logic [AW-1:0] id_dst = '0;
   logic id_wen = 1'b0;
   logic id_load = 1'b0;
   logic [2*NS-1:0] fwd_sel;
   logic stall_fd, bubble_ex;

   int checks = 0;
   int fails = 0;
   slot_t m_ex, m_mem, m_wb, cur;
   bit prev_stall = 0;

   always #2.5 clk = ~clk;

   hzfwd_unit dut_i (
      .clk(clk), .rst_n(rst_n), .id_vld(id_vld), .id_src(id_src),
      .id_used(id_used), .id_dst(id_dst), .id_wen(id_wen), .id_load(id_load),
      .fwd_sel(fwd_sel), .stall_fd(stall_fd), .bubble_ex(bubble_ex)
   );

   function automatic slot_t empty_slot();
      slot_t e;
      e.v = 0; e.w = 0; e.l = 0; e.d = 0;
      for (int i = 0; i < NS; i++) begin e.s[i] = 0; e.u[i] = 0; end
      return e;
   endfunction

   function automatic bit wr(slot_t p);
      return p.v && p.w && p.d != PC;
   endfunction

   function automatic int exp_sel(int i);
      if (!(m_ex.v && m_ex.u[i])) return 0;
      if (wr(m_mem) && m_mem.d == m_ex.s[i]) return 1;
      if (wr(m_wb) && m_wb.d == m_ex.s[i]) return 2;
      return 0;
   endfunction

   function automatic string sel_tag(int i);
      if (!(m_ex.v && m_ex.u[i])) return "R9";
      if (m_mem.v && m_mem.w && m_mem.d == PC && m_ex.s[i] == PC) return "R6";
      if (wr(m_mem) && m_mem.d == m_ex.s[i] && wr(m_wb) && m_wb.d == m_ex.s[i]) return "R4";
      if (prev_stall) return "R8";
      if (wr(m_mem) && m_mem.d == m_ex.s[i]) return (i == 2) ? "R10" : "R2";
      if (wr(m_wb) && m_wb.d == m_ex.s[i]) return "R3";
      return "R5";
   endfunction

   function automatic bit exp_stall(slot_t d);
      bit h = 0;
      if (!(d.v && wr(m_ex) && m_ex.l)) return 0;
      for (int i = 0; i < NS; i++) if (d.u[i] && d.s[i] == m_ex.d) h = 1;
      return h;
   endfunction

   task automatic chk(bit ok, string tag, int act, int expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, expv, $time);
      end
   endtask

   task automatic drive(slot_t d);
      id_vld = d.v; id_wen = d.w; id_load = d.l; id_dst = AW'(d.d);
      for (int i = 0; i < NS; i++) begin
         id_src[i*AW +: AW] = AW'(d.s[i]);
         id_used[i] = d.u[i];
      end
   endtask

   // one clock: check selects, present decode, check stall, advance model
   task automatic step(slot_t d, output bit st);
      @(negedge clk);
      for (int i = 0; i < NS; i++)
         chk(fwd_sel[2*i +: 2] == 2'(exp_sel(i)), sel_tag(i),
             int'(fwd_sel[2*i +: 2]), exp_sel(i));
      drive(d);
      #1;
      st = exp_stall(d);
      chk(stall_fd == st, st ? "R7" : (prev_stall ? "R8" : "R9"), int'(stall_fd), int'(st));
      chk(bubble_ex == st, "R7", int'(bubble_ex), int'(st));
      @(posedge clk);
      m_wb = m_mem; m_mem = m_ex;
      m_ex = st ? empty_slot() : d;
      prev_stall = st;
   endtask

   task automatic issue(slot_t d);
      bit st;
      int n = 0;
      do begin step(d, st); n++; end while (st && n < 4);
   endtask

   function automatic slot_t mk(int dst, bit w, bit l, int s0, bit u0, int s1, bit u1, int s2, bit u2);
      slot_t x = empty_slot();
      x.v = 1; x.d = dst; x.w = w; x.l = l;
      x.s[0] = s0; x.u[0] = u0; x.s[1] = s1; x.u[1] = u1; x.s[2] = s2; x.u[2] = u2;
      return x;
   endfunction

   function automatic int pick_reg();
      int r = $urandom_range(0, 4);
      return (r == 4) ? PC : r;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      m_ex = empty_slot(); m_mem = empty_slot(); m_wb = empty_slot();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R1 during reset
      chk(fwd_sel == '0, "R1", int'(fwd_sel), 0);
      chk(stall_fd == 1'b0, "R1", int'(stall_fd), 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(fwd_sel == '0 && !bubble_ex, "R1", int'(fwd_sel), 0);

      // R2/R3: r1 producer, then consumers on op0 and op2
      issue(mk(1, 1, 0, 2, 1, 3, 1, 0, 0));
      issue(mk(4, 1, 0, 1, 1, 0, 0, 0, 0));
      issue(mk(5, 1, 0, 0, 0, 0, 0, 1, 1));
      // R4: two writers of r2, consumer on op2
      issue(mk(2, 1, 0, 0, 0, 0, 0, 0, 0));
      issue(mk(2, 1, 0, 0, 0, 0, 0, 0, 0));
      issue(mk(6, 1, 0, 0, 0, 0, 0, 2, 1));
      // R6: writer of PC then reader of PC
      issue(mk(PC, 1, 0, 0, 0, 0, 0, 0, 0));
      issue(mk(7, 1, 0, PC, 1, 0, 0, 0, 0));
      // R5: no write enable
      issue(mk(3, 0, 0, 0, 0, 0, 0, 0, 0));
      issue(mk(8, 1, 0, 0, 0, 3, 1, 0, 0));
      // R7/R8: load r3 then consumer on op2, plus unused match (R9)
      issue(mk(3, 1, 1, 0, 0, 0, 0, 0, 0));
      issue(mk(9, 1, 0, 0, 0, 0, 0, 3, 1));
      issue(mk(10, 1, 1, 0, 0, 0, 0, 0, 0));
      issue(mk(11, 1, 0, 10, 0, 10, 0, 10, 0));
      // R6: load into PC does not stall
      issue(mk(PC, 1, 1, 0, 0, 0, 0, 0, 0));
      issue(mk(12, 1, 0, PC, 1, PC, 1, PC, 1));

      for (int k = 0; k < 4000; k++) begin
         slot_t r = empty_slot();
         r.v = ($urandom_range(0, 7) != 0);
         r.w = ($urandom_range(0, 3) != 0);
         r.l = ($urandom_range(0, 3) == 0);
         r.d = pick_reg();
         for (int i = 0; i < NS; i++) begin
            r.s[i] = pick_reg();
            r.u[i] = ($urandom_range(0, 3) != 0);
         end
         issue(r);
      end
      issue(empty_slot());
      issue(empty_slot());
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

endmodule